// File: doc/BRIEF.md
# CSI-2 Packet Admission Filter

This block sits between a CSI-2 packet receiver and the forwarding path behind it, and decides for each packet whether it goes on or is thrown away. Every packet is first written into a store-and-forward buffer. Its verdict is reached on its last beat, once the receiver has reported the packet's ECC, checksum and length error flags. An accepted packet is committed to the reader. A rejected packet is erased by moving the write pointer back to the last commit point, so no beat of it ever reaches the output.

Admission depends on two things: a frame-start synchronisation tracker and one forward-or-drop enable for each error class. The tracker keeps the filter closed until a Frame Start short packet arrives. It can be told to accept only a Frame Start whose frame number is 1. The 2-bit input-mode field selects packet mode (00) or one of three raw modes. The raw modes skip the synchronisation gate and the checksum rule. Saturating counters record why packets were dropped.

Top module: `csi_pkt_gate`

The intake state machine has three states:
- IN_IDLE waits for a start-of-packet beat.
- IN_FILL writes the body of a packet.
- IN_SPILL discards the rest of a packet that did not fit.

The transitions are:
- IN_IDLE to IN_FILL on a multi-beat start.
- IN_IDLE to IN_SPILL on a start that meets a full buffer.
- IN_FILL to IN_IDLE on the end beat.
- IN_FILL to IN_SPILL when the buffer fills.
- IN_SPILL to IN_IDLE on the end beat.

The sync tracker has two states, SY_WAIT and SY_LOCKED:
- SY_WAIT to SY_LOCKED when a qualifying Frame Start is admitted.
- SY_LOCKED to SY_WAIT on a rising edge of either wait control.

## Requirements
- R1: After reset, out_valid is 0, all five drop counters read 0 and the tracker is waiting for a Frame Start.
- R2: In packet mode (cfg_mode 00), while cfg_wait_fs is 1 and the tracker is waiting, every packet is dropped and counted in drop_sync_cnt until a Frame Start arrives. A Frame Start is a packet with data type 0x00 on in_dt; its in_field carries the frame number. That Frame Start is forwarded, and packets after it are admitted.
- R3: While cfg_wait_fs1 is 1 in packet mode, only a Frame Start whose frame number is 1 ends the waiting state. A Frame Start with any other number is dropped as a sync drop.
- R4: A 0-to-1 change on cfg_wait_fs or cfg_wait_fs1 returns the tracker to waiting. Otherwise it stays locked until reset.
- R5: A packet whose end beat carries in_err_ecc is forwarded when cfg_fwd_ecc is 1 and dropped and counted in drop_ecc_cnt when it is 0.
- R6: A packet whose end beat carries in_err_len is forwarded when cfg_fwd_len is 1 and dropped and counted in drop_len_cnt when it is 0.
- R7: In packet mode, a packet whose end beat carries in_err_cks is forwarded when cfg_fwd_cks is 1 and dropped and counted in drop_cks_cnt when it is 0.
- R8: A dropped packet is counted exactly once, against the first failing check in the order sync, ECC, length, checksum.
- R9: In the raw modes (cfg_mode 01, 10, 11), the sync gate and the checksum rule are skipped and never count. The ECC and length rules still apply.
- R10: Accepted packets leave in arrival order with their sop and eop markers and unchanged data. No beat of a packet is valid at the output before its end beat has been taken in, and no beat of a dropped packet is ever valid.
- R11: A packet longer than DEPTH beats is dropped whole and counted in drop_ovf_cnt. A packet of exactly DEPTH beats is accepted when the buffer is empty.
- R12: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sop and out_eop hold their values.
- R13: Each drop counter stops at its all-ones value (0xFFFF by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 packet mode; 01 raw 12-bit low rate; 10 raw 12-bit high rate; 11 raw 10-bit |
| cfg_wait_fs | input | 1 | Hold the gate shut until a Frame Start arrives |
| cfg_wait_fs1 | input | 1 | Require frame number 1 on the unlocking Frame Start |
| cfg_fwd_ecc | input | 1 | Forward packets flagged with an ECC error |
| cfg_fwd_cks | input | 1 | Forward packets flagged with a checksum error |
| cfg_fwd_len | input | 1 | Forward packets flagged with a length error |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_dt | input | 6 | Data type, valid on the first beat |
| in_field | input | 16 | Word count or frame number, valid on the first beat |
| in_data | input | DW | Beat payload |
| in_err_ecc | input | 1 | ECC error flag, valid on the last beat |
| in_err_cks | input | 1 | Checksum error flag, valid on the last beat |
| in_err_len | input | 1 | Length error flag, valid on the last beat |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream takes the beat |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |
| out_data | output | DW | Output payload |
| drop_sync_cnt | output | CW | Packets dropped while waiting for sync |
| drop_ecc_cnt | output | CW | Packets dropped for ECC errors |
| drop_len_cnt | output | CW | Packets dropped for length errors |
| drop_cks_cnt | output | CW | Packets dropped for checksum errors |
| drop_ovf_cnt | output | CW | Packets dropped for exceeding the buffer |

## Verification
The framing and hold properties assume that the receiver sends well-formed packets. Each packet opens with one sop beat, closes with one eop beat, and never begins a new packet before the old one has ended. The raw-mode properties assume that cfg_mode stays steady around each end beat. The stimulus only builds packets through a task that raises sop on the first beat and eop on the last. Control inputs are changed only while no packet is in flight.

// File: rtl/csi_gate_pkg.sv
package csi_gate_pkg;

    typedef enum logic [1:0] {
        IN_IDLE,
        IN_FILL,
        IN_SPILL
    } intake_t;

    typedef enum logic {
        SY_WAIT,
        SY_LOCKED
    } sync_t;

    // drop reason slots, also the order of the counter bank
    localparam int RSN_SYNC = 0;
    localparam int RSN_ECC  = 1;
    localparam int RSN_LEN  = 2;
    localparam int RSN_CKS  = 3;
    localparam int RSN_OVF  = 4;
    localparam int N_RSN    = 5;

    localparam logic [5:0] DT_FRAME_START = 6'h00;
    localparam logic [1:0] MODE_PACKET    = 2'b00;
    localparam logic [15:0] FRAME_ONE     = 16'd1;

endpackage

// File: rtl/csi_gate_sync.sv
module csi_gate_sync
    import csi_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_fs,
    input  logic wait_fs1,
    input  logic fs_ok,
    output logic locked
);

    sync_t st_q, st_d;
    logic  wait_fs_q, wait_fs1_q;
    logic  arm;

    // a newly enabled wait control re-arms the gate
    assign arm = (wait_fs & ~wait_fs_q) | (wait_fs1 & ~wait_fs1_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_fs_q  <= 1'b0;
            wait_fs1_q <= 1'b0;
        end else begin
            wait_fs_q  <= wait_fs;
            wait_fs1_q <= wait_fs1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SY_WAIT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_WAIT:   if (!arm && fs_ok) st_d = SY_LOCKED;
            SY_LOCKED: if (arm)           st_d = SY_WAIT;
            default:                      st_d = SY_WAIT;
        endcase
    end

    always_comb begin
        locked = (st_q == SY_LOCKED);
    end

endmodule

// File: rtl/csi_gate_judge.sv
module csi_gate_judge
    import csi_gate_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic             wait_fs,
    input  logic             wait_fs1,
    input  logic             fwd_ecc,
    input  logic             fwd_cks,
    input  logic             fwd_len,
    input  logic             locked,
    input  logic [5:0]       dt,
    input  logic [15:0]      field,
    input  logic             err_ecc,
    input  logic             err_cks,
    input  logic             err_len,
    output logic             pass,
    output logic             fs_ok,
    output logic [N_RSN-1:0] why
);

    logic raw, gating, fs_qual;
    logic blk_sync, blk_ecc, blk_len, blk_cks;

    always_comb begin
        raw      = (mode != MODE_PACKET);
        gating   = !raw && (wait_fs || wait_fs1);
        fs_qual  = (dt == DT_FRAME_START) && (!wait_fs1 || field == FRAME_ONE);
        blk_sync = gating && !locked && !fs_qual;
        blk_ecc  = err_ecc && !fwd_ecc;
        blk_len  = err_len && !fwd_len;
        blk_cks  = err_cks && !fwd_cks && !raw;

        why = '0;
        if (blk_sync)     why[RSN_SYNC] = 1'b1;
        else if (blk_ecc) why[RSN_ECC]  = 1'b1;
        else if (blk_len) why[RSN_LEN]  = 1'b1;
        else if (blk_cks) why[RSN_CKS]  = 1'b1;

        pass  = (why == '0);
        fs_ok = fs_qual && pass;
    end

endmodule

// File: rtl/csi_gate_store.sv
module csi_gate_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sop,
    input  logic          wr_eop,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          rewind,
    output logic          full,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic          rd_sop,
    output logic          rd_eop,
    output logic [DW-1:0] rd_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int WW = DW + 2;
    localparam logic [PW-1:0] GAP_FULL = PW'(DEPTH);
    localparam logic [PW-1:0] STEP     = PW'(1);

    logic [WW-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q, cp_q, rp_q;
    logic [WW-1:0] word;

    assign full     = (wp_q - rp_q) == GAP_FULL;
    assign rd_valid = (rp_q != cp_q);
    assign word     = mem[rp_q[AW-1:0]];
    assign rd_sop   = word[WW-1];
    assign rd_eop   = word[WW-2];
    assign rd_data  = word[DW-1:0];

    always_ff @(posedge clk) begin
        if (wr_en && !rewind) mem[wp_q[AW-1:0]] <= {wr_sop, wr_eop, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            cp_q <= '0;
        end else if (rewind) begin
            wp_q <= cp_q;
        end else if (wr_en) begin
            wp_q <= wp_q + STEP;
            if (commit) cp_q <= wp_q + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rp_q <= '0;
        else if (rd_valid && rd_ready) rp_q <= rp_q + STEP;
    end

endmodule

// File: rtl/csi_gate_tally.sv
module csi_gate_tally #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CEIL = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (inc && cnt != CEIL) cnt <= cnt + ONE;
    end

endmodule

// File: rtl/csi_pkt_gate.sv
module csi_pkt_gate
    import csi_gate_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_wait_fs,
    input  logic          cfg_wait_fs1,
    input  logic          cfg_fwd_ecc,
    input  logic          cfg_fwd_cks,
    input  logic          cfg_fwd_len,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [5:0]    in_dt,
    input  logic [15:0]   in_field,
    input  logic [DW-1:0] in_data,
    input  logic          in_err_ecc,
    input  logic          in_err_cks,
    input  logic          in_err_len,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sop,
    output logic          out_eop,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] drop_sync_cnt,
    output logic [CW-1:0] drop_ecc_cnt,
    output logic [CW-1:0] drop_len_cnt,
    output logic [CW-1:0] drop_cks_cnt,
    output logic [CW-1:0] drop_ovf_cnt
);

    intake_t st_q, st_d;
    logic [5:0]  hdr_dt_q;
    logic [15:0] hdr_field_q;
    logic [5:0]  dt_eff;
    logic [15:0] field_eff;

    logic buf_full, wr_en, commit, rewind, ovf_hit, judge_en;
    logic pass, fs_ok, locked;
    logic [N_RSN-1:0] why, bump;
    logic [CW-1:0] cnt_bank [N_RSN];

    // header is captured on the first beat; a one-beat packet uses it live
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_dt_q    <= '0;
            hdr_field_q <= '0;
        end else if (in_valid && in_sop) begin
            hdr_dt_q    <= in_dt;
            hdr_field_q <= in_field;
        end
    end

    assign dt_eff    = (st_q == IN_IDLE) ? in_dt    : hdr_dt_q;
    assign field_eff = (st_q == IN_IDLE) ? in_field : hdr_field_q;

    csi_gate_judge u_judge (
        .mode     (cfg_mode),
        .wait_fs  (cfg_wait_fs),
        .wait_fs1 (cfg_wait_fs1),
        .fwd_ecc  (cfg_fwd_ecc),
        .fwd_cks  (cfg_fwd_cks),
        .fwd_len  (cfg_fwd_len),
        .locked   (locked),
        .dt       (dt_eff),
        .field    (field_eff),
        .err_ecc  (in_err_ecc),
        .err_cks  (in_err_cks),
        .err_len  (in_err_len),
        .pass     (pass),
        .fs_ok    (fs_ok),
        .why      (why)
    );

    csi_gate_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_fs  (cfg_wait_fs),
        .wait_fs1 (cfg_wait_fs1),
        .fs_ok    (judge_en & fs_ok),
        .locked   (locked)
    );

    // intake state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IN_IDLE;
        else        st_q <= st_d;
    end

    // intake decisions
    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        commit   = 1'b0;
        rewind   = 1'b0;
        ovf_hit  = 1'b0;
        judge_en = 1'b0;
        unique case (st_q)
            IN_IDLE: begin
                if (in_valid && in_sop) begin
                    if (buf_full) begin
                        if (in_eop) ovf_hit = 1'b1;
                        else        st_d    = IN_SPILL;
                    end else if (in_eop) begin
                        judge_en = 1'b1;
                        wr_en    = pass;
                        commit   = pass;
                    end else begin
                        wr_en = 1'b1;
                        st_d  = IN_FILL;
                    end
                end
            end
            IN_FILL: begin
                if (in_valid) begin
                    if (buf_full) begin
                        rewind = 1'b1;
                        if (in_eop) begin
                            ovf_hit = 1'b1;
                            st_d    = IN_IDLE;
                        end else begin
                            st_d = IN_SPILL;
                        end
                    end else if (in_eop) begin
                        judge_en = 1'b1;
                        st_d     = IN_IDLE;
                        wr_en    = pass;
                        commit   = pass;
                        rewind   = !pass;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
            end
            IN_SPILL: begin
                if (in_valid && in_eop) begin
                    ovf_hit = 1'b1;
                    st_d    = IN_IDLE;
                end
            end
            default: st_d = IN_IDLE;
        endcase
    end

    csi_gate_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sop   (in_sop),
        .wr_eop   (in_eop),
        .wr_data  (in_data),
        .commit   (commit),
        .rewind   (rewind),
        .full     (buf_full),
        .rd_valid (out_valid),
        .rd_ready (out_ready),
        .rd_sop   (out_sop),
        .rd_eop   (out_eop),
        .rd_data  (out_data)
    );

    always_comb begin
        bump          = judge_en ? why : '0;
        bump[RSN_OVF] = ovf_hit;
    end

    for (genvar g = 0; g < N_RSN; g++) begin : g_tally
        csi_gate_tally #(.CW(CW)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump[g]),
            .cnt   (cnt_bank[g])
        );
    end

    assign drop_sync_cnt = cnt_bank[RSN_SYNC];
    assign drop_ecc_cnt  = cnt_bank[RSN_ECC];
    assign drop_len_cnt  = cnt_bank[RSN_LEN];
    assign drop_cks_cnt  = cnt_bank[RSN_CKS];
    assign drop_ovf_cnt  = cnt_bank[RSN_OVF];

endmodule

// File: rtl/csi_pkt_gate_chk.sv
module csi_pkt_gate_chk #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_sop,
    input logic          out_eop,
    input logic [DW-1:0] out_data,
    input logic [CW-1:0] drop_sync_cnt,
    input logic [CW-1:0] drop_ecc_cnt,
    input logic [CW-1:0] drop_cks_cnt
);

    localparam logic [CW-1:0] CEIL = '1;

    logic mid_pkt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     mid_pkt <= 1'b0;
        else if (out_valid && out_ready) mid_pkt <= !out_eop;
    end

    assert_hold_under_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    assert_sop_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !mid_pkt |-> out_sop);

    assert_no_sop_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mid_pkt |-> !out_sop);

    assert_raw_no_sync_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_mode) != 2'b00 |-> $stable(drop_sync_cnt));

    assert_raw_no_cks_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_mode) != 2'b00 |-> $stable(drop_cks_cnt));

    assert_ecc_saturates_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drop_ecc_cnt) == CEIL |-> drop_ecc_cnt == CEIL);

    assert_sync_never_falls_R13: assert property (@(posedge clk) disable iff (!rst_n)
        drop_sync_cnt >= $past(drop_sync_cnt));

endmodule

bind csi_pkt_gate csi_pkt_gate_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_sop       (out_sop),
    .out_eop       (out_eop),
    .out_data      (out_data),
    .drop_sync_cnt (drop_sync_cnt),
    .drop_ecc_cnt  (drop_ecc_cnt),
    .drop_cks_cnt  (drop_cks_cnt)
);

// File: tb/test_csi_pkt_gate.sv
module test_csi_pkt_gate;

    localparam int DW    = 16;
    localparam int DEPTH = 64;
    localparam int CW    = 16;
    localparam int WW    = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_wait_fs = 1'b1;
    logic          cfg_wait_fs1 = 1'b0;
    logic          cfg_fwd_ecc = 1'b1;
    logic          cfg_fwd_cks = 1'b1;
    logic          cfg_fwd_len = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [5:0]    in_dt = '0;
    logic [15:0]   in_field = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_err_ecc = 1'b0;
    logic          in_err_cks = 1'b0;
    logic          in_err_len = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_sop;
    logic          out_eop;
    logic [DW-1:0] out_data;
    logic [CW-1:0] drop_sync_cnt, drop_ecc_cnt, drop_len_cnt, drop_cks_cnt, drop_ovf_cnt;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pid = 8'd0;
    logic [WW-1:0] exp_q [$];

    always #5 clk = ~clk;

    csi_pkt_gate #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) i_csi_pkt_gate (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_wait_fs(cfg_wait_fs), .cfg_wait_fs1(cfg_wait_fs1),
        .cfg_fwd_ecc(cfg_fwd_ecc), .cfg_fwd_cks(cfg_fwd_cks), .cfg_fwd_len(cfg_fwd_len),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_dt(in_dt),
        .in_field(in_field), .in_data(in_data), .in_err_ecc(in_err_ecc),
        .in_err_cks(in_err_cks), .in_err_len(in_err_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data),
        .drop_sync_cnt(drop_sync_cnt), .drop_ecc_cnt(drop_ecc_cnt),
        .drop_len_cnt(drop_len_cnt), .drop_cks_cnt(drop_cks_cnt),
        .drop_ovf_cnt(drop_ovf_cnt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver: one packet, expected beats go to the scoreboard queue
    task automatic send_pkt(input logic [5:0] dt, input logic [15:0] fld, input int nb,
                            input bit e_ecc, input bit e_len, input bit e_cks,
                            input bit exp_pass, input bit watch_sf);
        pid++;
        for (int b = 0; b < nb; b++) begin
            @(posedge clk); #2;
            in_valid   = 1'b1;
            in_sop     = (b == 0);
            in_eop     = (b == nb - 1);
            in_dt      = dt;
            in_field   = fld;
            in_data    = {pid, 8'(b)};
            in_err_ecc = (b == nb - 1) && e_ecc;
            in_err_len = (b == nb - 1) && e_len;
            in_err_cks = (b == nb - 1) && e_cks;
            if (exp_pass) exp_q.push_back({in_sop, in_eop, in_data});
            if (watch_sf) begin
                @(negedge clk);
                chk(out_valid == 1'b0, "R10 beat visible before end of packet", 32'(out_valid), 0);
            end
        end
        @(posedge clk); #2;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_err_ecc = 1'b0; in_err_len = 1'b0; in_err_cks = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic chk_cnts(input string tag, input int s, input int e, input int l, input int c, input int o);
        chk(drop_sync_cnt == CW'(s), {tag, " sync count"}, 32'(drop_sync_cnt), s);
        chk(drop_ecc_cnt  == CW'(e), {tag, " ecc count"},  32'(drop_ecc_cnt),  e);
        chk(drop_len_cnt  == CW'(l), {tag, " len count"},  32'(drop_len_cnt),  l);
        chk(drop_cks_cnt  == CW'(c), {tag, " cks count"},  32'(drop_cks_cnt),  c);
        chk(drop_ovf_cnt  == CW'(o), {tag, " ovf count"},  32'(drop_ovf_cnt),  o);
    endtask

    // monitor: compare every handshaken output beat against the queue
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected output beat", 32'({out_sop, out_eop, out_data}), 0);
            end else begin
                logic [WW-1:0] e;
                e = exp_q.pop_front();
                chk({out_sop, out_eop, out_data} == e, "R10 output beat",
                    32'({out_sop, out_eop, out_data}), 32'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        summary();
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk_cnts("R1", 0, 0, 0, 0, 0);

        // R2 waiting: data packet dropped, then a Frame Start unlocks
        send_pkt(6'h2B, 16'd8, 4, 0, 0, 0, 0, 0);
        drain();
        chk_cnts("R2 blocked", 1, 0, 0, 0, 0);
        send_pkt(6'h00, 16'd7, 1, 0, 0, 0, 1, 0);
        send_pkt(6'h2B, 16'd6, 3, 0, 0, 0, 1, 0);
        drain();

        // R10 store and forward
        send_pkt(6'h2B, 16'd10, 5, 0, 0, 0, 1, 1);
        drain();

        // R5 ECC rule
        cfg_fwd_ecc = 1'b0;
        send_pkt(6'h2B, 16'd4, 2, 1, 0, 0, 0, 0);
        cfg_fwd_ecc = 1'b1;
        send_pkt(6'h2B, 16'd4, 2, 1, 0, 0, 1, 0);
        drain();
        chk_cnts("R5", 1, 1, 0, 0, 0);

        // R6 length rule, R7 checksum rule
        cfg_fwd_len = 1'b0;
        send_pkt(6'h2B, 16'd4, 3, 0, 1, 0, 0, 0);
        cfg_fwd_len = 1'b1;
        send_pkt(6'h2B, 16'd4, 3, 0, 1, 0, 1, 0);
        cfg_fwd_cks = 1'b0;
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 1, 0, 0);
        cfg_fwd_cks = 1'b1;
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 1, 1, 0);
        drain();
        chk_cnts("R6 R7", 1, 1, 1, 1, 0);

        // R8 priority: ECC before length before checksum
        cfg_fwd_ecc = 1'b0; cfg_fwd_len = 1'b0; cfg_fwd_cks = 1'b0;
        send_pkt(6'h2B, 16'd4, 2, 1, 1, 1, 0, 0);
        send_pkt(6'h2B, 16'd4, 2, 0, 1, 1, 0, 0);
        drain();
        chk_cnts("R8", 1, 2, 2, 1, 0);
        cfg_fwd_ecc = 1'b1; cfg_fwd_len = 1'b1; cfg_fwd_cks = 1'b1;

        // R4 re-arm on rising wait control
        cfg_wait_fs = 1'b0;
        repeat (2) @(posedge clk);
        #2 cfg_wait_fs = 1'b1;
        repeat (2) @(posedge clk);
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 0, 0, 0);
        drain();
        chk_cnts("R4", 2, 2, 2, 1, 0);

        // R3 frame number 1 required
        cfg_wait_fs1 = 1'b1;
        repeat (2) @(posedge clk);
        send_pkt(6'h00, 16'd2, 1, 0, 0, 0, 0, 0);
        send_pkt(6'h00, 16'd1, 1, 0, 0, 0, 1, 0);
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 0, 1, 0);
        drain();
        chk_cnts("R3", 3, 2, 2, 1, 0);

        // R9 raw modes skip sync and checksum, keep ECC
        cfg_mode = 2'b01;
        cfg_wait_fs1 = 1'b0;
        repeat (2) @(posedge clk);
        #2 cfg_wait_fs1 = 1'b1;
        repeat (2) @(posedge clk);
        cfg_fwd_cks = 1'b0; cfg_fwd_ecc = 1'b0;
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 0, 1, 0);
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 1, 1, 0);
        send_pkt(6'h2B, 16'd4, 2, 1, 0, 0, 0, 0);
        cfg_mode = 2'b11;
        send_pkt(6'h2C, 16'd4, 3, 0, 0, 1, 1, 0);
        drain();
        chk_cnts("R9 raw", 3, 3, 2, 1, 0);
        cfg_fwd_cks = 1'b1; cfg_fwd_ecc = 1'b1;
        cfg_mode = 2'b00;
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 0, 0, 0);
        send_pkt(6'h00, 16'd1, 1, 0, 0, 0, 1, 0);
        drain();
        chk_cnts("R9 back to packet mode", 4, 3, 2, 1, 0);

        // R12 hold under stall
        out_ready = 1'b0;
        send_pkt(6'h2B, 16'd4, 3, 0, 0, 0, 1, 0);
        send_pkt(6'h2B, 16'd4, 2, 0, 0, 0, 1, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R12 valid while stalled", 32'(out_valid), 1);
        held = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == held && out_sop == 1'b1, "R12 data held",
            32'(out_data), 32'(held));
        @(posedge clk); #2 out_ready = 1'b1;
        drain();

        // R11 oversize packet dropped whole; exactly DEPTH beats passes
        send_pkt(6'h2B, 16'd4, DEPTH + 3, 0, 0, 0, 0, 0);
        drain();
        chk_cnts("R11 oversize", 4, 3, 2, 1, 1);
        send_pkt(6'h2B, 16'd4, DEPTH, 0, 0, 0, 1, 0);
        drain();
        chk(exp_q.size() == 0, "R11 full-depth packet delivered", 32'(exp_q.size()), 0);

        // R13 saturation with back-to-back one-beat ECC drops
        cfg_fwd_ecc = 1'b0;
        for (int i = 0; i < 65540; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1;
            in_dt = 6'h12; in_err_ecc = 1'b1;
        end
        @(posedge clk); #2;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err_ecc = 1'b0;
        drain();
        chk(drop_ecc_cnt == 16'hFFFF, "R13 ecc counter saturates", 32'(drop_ecc_cnt), 32'hFFFF);
        chk_cnts("R13 others untouched", 4, 65535, 2, 1, 1);
        chk(exp_q.size() == 0, "R10 scoreboard empty", 32'(exp_q.size()), 0);
        summary();
    end

endmodule